// File: doc/BRIEF.md
# Multichannel Sync and Reset Control

This block holds the two host-facing control registers of a four-channel datapath whose writes act at once, with no staging byte. A host write selects one of two registers with `reg_sel` and supplies one data byte. Selecting the reset register sets the hold-in-reset level of each channel whose bit in the low nibble is 1. Selecting the sync register issues a command. The command byte has a channel mask (bit 0 is channel A through bit 3 for channel D) and a type mask (bit 4 start, bit 5 hop, bit 6 beam). One write fires every requested type to every selected channel.

Each sync output is a one-cycle pulse. A start sync also releases the reset level of each channel it reaches. The channel reset levels can therefore only be cleared through a start sync, which lets several channels leave reset on the same cycle. The reset register can be read back. The sync register is write-only and holds no command.

Top module: `mpc_sync_reset_ctrl`

## Requirements
- R1: After `rst_n` is released, all four `chan_reset` bits are 1 and no sync pulse is active.
- R2: A write with `reg_sel`=1 produces, in the clock cycle after the write edge, a pulse on `start_pulse[i]`, `hop_pulse[i]` or `beam_pulse[i]` for every channel i whose bit i (i = 0 to 3) is 1 and whose type bit is 1 (bit 4 start, bit 5 hop, bit 6 beam). No other sync output pulses.
- R3: Each sync pulse lasts exactly one cycle unless a further sync write requests the same type and channel on the next cycle.
- R4: Bit 7 of a sync write has no effect on any output.
- R5: A start sync to channel i clears `chan_reset[i]` on the same edge that raises `start_pulse[i]`. Hop and beam syncs leave `chan_reset` unchanged.
- R6: A write with `reg_sel`=0 sets `chan_reset[i]` for each data bit i in [3:0] that is 1. Zero bits leave their channel unchanged, and bits [7:4] are ignored.
- R7: `rd_data` shows {4'b0000, `chan_reset`} when `reg_sel`=0 and shows 0 when `reg_sel`=1.
- R8: A cycle without `wr_en` produces no sync pulse on the following cycle and leaves `chan_reset` unchanged, whatever `reg_sel` and `wr_data` hold.
- R9: A sync write with an empty channel mask or an empty type mask produces no pulse and changes no reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the reset register, 1 the sync register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Readback of the selected register |
| chan_reset | output | 4 | Held reset level per channel |
| start_pulse | output | 4 | Start sync pulse per channel |
| hop_pulse | output | 4 | Hop sync pulse per channel |
| beam_pulse | output | 4 | Beam sync pulse per channel |

## Verification
The case that is hardest to reach from the ports is a start sync that lands on a channel whose reset bit is set, while other selected channels get only hop or beam. The outcome depends on the reset bits the earlier writes left behind. For that reason the bench first writes all ones to the reset register, then sends each of the 256 sync bytes in turn. After each byte it checks the pulses and the remaining reset bits against masks computed from that byte. A second sweep first clears every channel with a start sync to all channels, then sends each of the 256 reset bytes. After that it writes zero to show that a zero bit clears nothing. Back-to-back sync writes and idle cycles with active data show the pulse width and that the write strobe gates every change.

// File: rtl/mpc_pkg.sv
// Shared constants and types for the sync and reset control block.
// Assumes the command layout is fixed: channel mask in the low bits,
// then one bit per sync type in the fixed order start, hop, beam.
package mpc_pkg;
    localparam int NUM_KIND = 3;       // start, hop, beam
    localparam int KIND_START = 0;
    localparam int KIND_HOP   = 1;
    localparam int KIND_BEAM  = 2;

    typedef enum logic {
        SEL_RESET = 1'b0,
        SEL_SYNC  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/mpc_sync_pulse_gen.sv
// Decodes a sync command into per-type, per-channel one-cycle pulses.
// Assumes cmd_valid is high only for a write to the sync register.
module mpc_sync_pulse_gen #(
    parameter int NUM_CH   = 4,
    parameter int NUM_KIND = 3,
    localparam int FIELD_W = NUM_CH + NUM_KIND
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic [FIELD_W-1:0]             cmd_field,
    output logic [NUM_KIND-1:0][NUM_CH-1:0] pulse
);
    logic [NUM_CH-1:0] chan_mask;
    assign chan_mask = cmd_field[NUM_CH-1:0];

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
        // Register this type's channel mask for one cycle when requested.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pulse[k] <= '0;
            else if (cmd_valid && cmd_field[NUM_CH + k])
                pulse[k] <= chan_mask;
            else
                pulse[k] <= '0;
        end
    end
endmodule

// File: rtl/mpc_chan_reset_bank.sv
// Holds one reset level per channel: set by host mask, cleared by start.
// Assumes set and clear never address the same channel in one cycle;
// if they do, the set wins.
module mpc_chan_reset_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] level
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Per-channel reset flag, asserted out of device reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                level[i] <= 1'b1;
            else if (set_mask[i])
                level[i] <= 1'b1;
            else if (clr_mask[i])
                level[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/mpc_sync_reset_ctrl.sv
// Top level: routes host writes to the reset bank or the sync decoder
// and multiplexes the readback byte. Assumes one write per wr_en cycle
// and DATA_W >= NUM_CH + NUM_KIND + 1.
module mpc_sync_reset_ctrl
    import mpc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] chan_reset,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] hop_pulse,
    output logic [NUM_CH-1:0] beam_pulse
);
    localparam int FIELD_W = NUM_CH + NUM_KIND;

    logic                            wr_reset, wr_sync;
    logic [FIELD_W-1:0]              field;
    logic [NUM_CH-1:0]               set_mask, clr_mask;
    logic [NUM_KIND-1:0][NUM_CH-1:0] pulses;
    logic                            unused_hi;

    // Steer the write strobe to the addressed register.
    always_comb begin
        wr_reset = wr_en && (reg_sel_e'(reg_sel) == SEL_RESET);
        wr_sync  = wr_en && (reg_sel_e'(reg_sel) == SEL_SYNC);
    end

    assign field     = wr_data[FIELD_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:FIELD_W];

    // Build the set and clear masks for the reset bank.
    always_comb begin
        set_mask = wr_reset ? wr_data[NUM_CH-1:0] : '0;
        clr_mask = (wr_sync && field[NUM_CH + KIND_START]) ? field[NUM_CH-1:0] : '0;
    end

    mpc_chan_reset_bank #(.NUM_CH(NUM_CH)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .level    (chan_reset)
    );

    mpc_sync_pulse_gen #(.NUM_CH(NUM_CH), .NUM_KIND(NUM_KIND)) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (wr_sync),
        .cmd_field (field),
        .pulse     (pulses)
    );

    assign start_pulse = pulses[KIND_START];
    assign hop_pulse   = pulses[KIND_HOP];
    assign beam_pulse  = pulses[KIND_BEAM];

    // Readback: reset bits zero-extended; the sync register reads as zero.
    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_RESET)
            rd_data = {{(DATA_W-NUM_CH){1'b0}}, chan_reset};
        else
            rd_data = '0;
    end
endmodule

// File: rtl/mpc_ctrl_checker.sv
// Property checker for mpc_sync_reset_ctrl, bound to every instance.
// Assumes the default command layout (start at bit NUM_CH).
module mpc_ctrl_checker #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [NUM_CH-1:0] chan_reset,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] hop_pulse,
    input logic [NUM_CH-1:0] beam_pulse
);
    // R2: any pulse must stem from a sync write on the previous cycle
    a_r2_pulse_needs_sync_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|{start_pulse, hop_pulse, beam_pulse}) |-> $past(wr_en && reg_sel));

    // R5: a channel being started is out of reset on that cycle
    a_r5_start_clears_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_pulse) |-> ((start_pulse & chan_reset) == '0));

    // R6: a reset write leaves every requested bit set
    a_r6_reset_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel) |=> ((chan_reset & $past(wr_data[NUM_CH-1:0]))
                                 == $past(wr_data[NUM_CH-1:0])));

    // R7: the sync register never returns data
    a_r7_sync_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data == '0));

    // R8: no write strobe, no pulse and no reset change
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (({start_pulse, hop_pulse, beam_pulse} == '0) && $stable(chan_reset)));

    // R5: hop or beam only never drops a reset bit
    a_r5_hop_beam_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && !wr_data[NUM_CH]) |=> $stable(chan_reset));
endmodule

bind mpc_sync_reset_ctrl mpc_ctrl_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .reg_sel     (reg_sel),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .chan_reset  (chan_reset),
    .start_pulse (start_pulse),
    .hop_pulse   (hop_pulse),
    .beam_pulse  (beam_pulse)
);

// File: tb/test_mpc_sync_reset_ctrl.sv
// Self-checking bench: exhaustive sweeps of sync and reset bytes.
module test_mpc_sync_reset_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] chan_reset, start_pulse, hop_pulse, beam_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mpc_sync_reset_ctrl i_mpc_sync_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .chan_reset(chan_reset),
        .start_pulse(start_pulse), .hop_pulse(hop_pulse), .beam_pulse(beam_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic host_write(input logic sel, input logic [7:0] d);
        reg_sel = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] exp_rst;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset bits", chan_reset, 4'hF);
        chk("R1 pulses", {start_pulse, hop_pulse, beam_pulse}, 12'h000);

        // R2 R4 R5 R9: sweep of every sync byte from an all-set state
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            logic [3:0] ch, e_st, e_hp, e_bm;
            v = 8'(b);
            ch = v[3:0];
            e_st = v[4] ? ch : 4'h0;
            e_hp = v[5] ? ch : 4'h0;
            e_bm = v[6] ? ch : 4'h0;
            host_write(1'b0, 8'h0F);
            host_write(1'b1, v);
            chk("R2 start", start_pulse, e_st);
            chk("R2 hop", hop_pulse, e_hp);
            chk("R2 beam", beam_pulse, e_bm);
            chk("R5 reset after sync", chan_reset, 4'hF & ~e_st);
            if (ch == 0 || v[6:4] == 0)
                chk("R9 empty mask", {start_pulse, hop_pulse, beam_pulse, chan_reset}, 16'h000F);
            @(negedge clk);
            chk("R3 pulse ends", {start_pulse, hop_pulse, beam_pulse}, 12'h000);
        end
        // R4: bit 7 set versus clear, identical outcome
        host_write(1'b0, 8'h0F);
        host_write(1'b1, 8'h94);
        chk("R4 bit7 start", start_pulse, 4'h4);
        chk("R4 bit7 others", {hop_pulse, beam_pulse}, 8'h00);
        chk("R4 bit7 reset", chan_reset, 4'hB);
        host_write(1'b0, 8'h0F);
        host_write(1'b1, 8'hEF);
        chk("R4 hop all", hop_pulse, 4'hF);
        chk("R4 beam all", beam_pulse, 4'hF);
        chk("R4 start none", start_pulse, 4'h0);

        // R6 R7: sweep of every reset byte from an all-clear state
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            v = 8'(b);
            host_write(1'b1, 8'h1F);
            chk("R5 start all clears", chan_reset, 4'h0);
            host_write(1'b0, v);
            chk("R6 set mask", chan_reset, v[3:0]);
            host_write(1'b0, 8'h00);
            chk("R6 zero keeps", chan_reset, v[3:0]);
            reg_sel = 1'b0;
            #1;
            chk("R7 reset readback", rd_data, {4'h0, v[3:0]});
            reg_sel = 1'b1;
            #1;
            chk("R7 sync reads zero", rd_data, 8'h00);
        end

        // R8: idle cycles with active-looking data
        exp_rst = chan_reset;
        reg_sel = 1'b1;
        wr_data = 8'hFF;
        @(negedge clk);
        chk("R8 idle sync pulses", {start_pulse, hop_pulse, beam_pulse}, 12'h000);
        chk("R8 idle sync reset", chan_reset, exp_rst);
        reg_sel = 1'b0;
        wr_data = 8'h0F;
        host_write(1'b1, 8'h1F);
        reg_sel = 1'b0;
        wr_data = 8'h0F;
        @(negedge clk);
        chk("R8 idle reset sel", chan_reset, 4'h0);

        // R3: back-to-back sync writes
        reg_sel = 1'b1;
        wr_data = 8'h11;
        wr_en = 1'b1;
        @(negedge clk);
        chk("R3 first pulse", {start_pulse, hop_pulse}, 8'h10);
        wr_data = 8'h22;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 second pulse", {start_pulse, hop_pulse}, 8'h02);
        @(negedge clk);
        chk("R3 both end", {start_pulse, hop_pulse, beam_pulse}, 12'h000);
        // R3: same pulse held by repeated write
        host_write(1'b1, 8'h48);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 repeated beam", beam_pulse, 4'h8);
        @(negedge clk);
        chk("R3 repeated ends", beam_pulse, 4'h0);

        // R1: reset reapplied mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset bits", chan_reset, 4'hF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule